// File: doc/BRIEF.md
# Programmable Tapped Delay Line

This block delays a stream of words by a number of clock cycles chosen at run time, anywhere from 0 to 63. The word passes through six register chains of 32, 16, 8, 4, 2 and 1 stages, placed in that order from the input side to the output side. After each chain sits a two-way selector that either takes the chain's output or skips the chain. Bit i of the 6-bit delay word drives the selector after the chain of 2^i stages. The total delay is therefore the plain binary value of the delay word.

Each stage holds one full data word plus a valid flag, and the flag travels with its word. The stream has no back-pressure. A word is taken on every clock, whatever the value of `in_valid`, and the consumer must take `out_data` whenever `out_valid` is high, because the line cannot stall. Every chain shifts on every clock, including a chain that is currently skipped. When the delay word changes, the output may repeat or drop samples until the new delay has elapsed.

Top module: `prog_delay_line`

## Requirements
- R1: A synchronous reset clears every stage. For one or more cycles after reset, with a nonzero delay, `out_valid` and `out_data` read 0 until real input reaches the output.
- R2: With a delay word of 0, `out_valid`/`out_data` equal `in_valid`/`in_data` in the same cycle, with no register in the path.
- R3: With a delay word d from 1 to 63 held constant for more than d cycles, the output in cycle n equals the input of cycle n-d.
- R4: Bit i of `delay_sel` (bit 0 is the least significant) enables the chain of 2^i stages. Each single-bit setting 1, 2, 4, 8, 16 or 32 gives exactly that delay.
- R5: Combined settings give the sum of the enabled chain lengths, for example 5, 42 and 63.
- R6: Every chain shifts on every clock even while it is skipped. After a long run at delay 0, switching to 32 or to 1 yields the input from 32 or 1 cycles back, starting in the very next cycle.
- R7: The valid flag is delayed exactly like its word. The line takes a word on every clock and never applies back-pressure, so gaps in `in_valid` show up at the output unchanged in position.
- R8: After the delay word changes from one nonzero value to another, the output follows R3 for the new value once the new delay has elapsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| delay_sel | input | NUM_SEG (6) | Delay in cycles, binary; bit i enables the 2^i-stage chain |
| in_valid | input | 1 | Input word is meaningful |
| in_data | input | WIDTH (8) | Input word |
| out_valid | output | 1 | Delayed valid flag |
| out_data | output | WIDTH (8) | Delayed word |

## Verification
The input is a counting-hash word stream with a valid flag that drops every fifth cycle. This lets a wrong tap, an off-by-one delay and a flag that drifts from its word each show up as a clear mismatch. Each single-bit delay is tried alone to show which chain each bit controls. Combined values such as 5, 42 and 63 show that the chain lengths add. Zero delay is checked in the same cycle as the input, to show the path has no register. Two switches are made straight out of a long zero-delay run, to 32 and to 1, and the output is checked in the next cycle; this shows that skipped chains keep shifting. A change from 5 to 12 is checked once the new delay has elapsed.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  // Number of register stages held by chain number idx (binary weighted).
  function automatic int unsigned seg_len(int unsigned idx);
    return 32'd1 << idx;
  endfunction
endpackage

// File: rtl/tdl_segment.sv
module tdl_segment #(
  parameter int WIDTH = 8,
  parameter int LEN   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vin,
  input  logic [WIDTH-1:0] din,
  output logic             vout,
  output logic [WIDTH-1:0] dout
);
  localparam int SW = WIDTH + 1;

  logic [SW-1:0] stage [LEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LEN; k++) stage[k] <= '0;
    end else begin
      stage[0] <= {vin, din};
      for (int k = 1; k < LEN; k++) stage[k] <= stage[k-1];
    end
  end

  assign {vout, dout} = stage[LEN-1];

  // R1
  seg_clear_chk: assert property (@(posedge clk) rst |=> (!vout && dout == '0));

  generate
    if (LEN == 1) begin : g_single
      // R3
      single_stage_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ({vout, dout} == $past({vin, din})));
    end
  endgenerate
endmodule

// File: rtl/tdl_bypass.sv
module tdl_bypass #(
  parameter int WIDTH = 8
) (
  input  logic             take_seg,
  input  logic             skip_v,
  input  logic [WIDTH-1:0] skip_d,
  input  logic             seg_v,
  input  logic [WIDTH-1:0] seg_d,
  output logic             sel_v,
  output logic [WIDTH-1:0] sel_d
);
  always_comb begin
    if (take_seg) begin
      sel_v = seg_v;
      sel_d = seg_d;
    end else begin
      sel_v = skip_v;
      sel_d = skip_d;
    end
  end
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int WIDTH   = 8,
  parameter int NUM_SEG = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SEG-1:0] delay_sel,
  input  logic               in_valid,
  input  logic [WIDTH-1:0]   in_data,
  output logic               out_valid,
  output logic [WIDTH-1:0]   out_data
);
  localparam logic [NUM_SEG-1:0] ZERO_TAP = '0;
  localparam logic [NUM_SEG-1:0] ONE_TAP  = NUM_SEG'(1);

  // link[NUM_SEG] is the block input; link[0] feeds the output.
  logic [WIDTH-1:0] link_d [NUM_SEG+1];
  logic             link_v [NUM_SEG+1];

  assign link_d[NUM_SEG] = in_data;
  assign link_v[NUM_SEG] = in_valid;

  generate
    for (genvar g = NUM_SEG - 1; g >= 0; g--) begin : g_seg
      localparam int LEN = int'(tdl_pkg::seg_len(g));
      logic             s_v;
      logic [WIDTH-1:0] s_d;

      tdl_segment #(.WIDTH(WIDTH), .LEN(LEN)) seg_i (
        .clk  (clk),
        .rst  (rst),
        .vin  (link_v[g+1]),
        .din  (link_d[g+1]),
        .vout (s_v),
        .dout (s_d)
      );

      tdl_bypass #(.WIDTH(WIDTH)) mux_i (
        .take_seg (delay_sel[g]),
        .skip_v   (link_v[g+1]),
        .skip_d   (link_d[g+1]),
        .seg_v    (s_v),
        .seg_d    (s_d),
        .sel_v    (link_v[g]),
        .sel_d    (link_d[g])
      );
    end
  endgenerate

  assign out_valid = link_v[0];
  assign out_data  = link_d[0];

  // R2
  always_comb begin
    if (delay_sel == ZERO_TAP) begin
      zero_delay_chk: assert (out_valid == in_valid && out_data == in_data);
    end
  end

  // R3
  one_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (delay_sel == ONE_TAP && $past(delay_sel) == ONE_TAP && !$past(rst))
      |-> ({out_valid, out_data} == $past({in_valid, in_data})));

  // R7
  valid_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (delay_sel == ZERO_TAP && !in_valid) |-> !out_valid);
endmodule

// File: tb/prog_delay_line_tb_top.sv
`timescale 1ns/1ps
module prog_delay_line_tb_top;
  localparam int W  = 8;
  localparam int NS = 6;
  localparam int HL = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] dsel = '0;
  logic          iv = 1'b0;
  logic [W-1:0]  id = '0;
  logic          ov;
  logic [W-1:0]  od;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  logic [W:0] hist [HL];

  always #2.5 clk = ~clk;

  prog_delay_line #(.WIDTH(W), .NUM_SEG(NS)) dut_i (
    .clk(clk), .rst(rst), .delay_sel(dsel),
    .in_valid(iv), .in_data(id), .out_valid(ov), .out_data(od)
  );

  // One cycle: drive new inputs at the falling edge, record them, settle.
  task automatic step();
    @(negedge clk);
    cyc++;
    id = W'(cyc * 29 + 7) ^ W'(cyc >> 3);
    iv = ((cyc % 5) != 3);
    hist[cyc % HL] = rst ? '0 : {iv, id};
    #1;
  endtask

  task automatic check(input int d, input string tag);
    logic [W:0] exp;
    exp = (cyc - d > 0) ? hist[(cyc - d) % HL] : '0;
    checks++;
    if ({ov, od} !== exp) begin
      fails++;
      $display("FAIL %s delay=%0d cyc=%0d got=%h exp=%h", tag, d, cyc, {ov, od}, exp);
    end
  endtask

  task automatic settle_and_check(input int d, input int n, input string tag);
    dsel = NS'(d);
    for (int k = 0; k <= d; k++) step();
    for (int k = 0; k < n; k++) begin
      step();
      check(d, tag);
    end
  endtask

  task automatic t_reset();
    dsel = NS'(7);
    rst = 1'b1;
    for (int k = 0; k < 4; k++) step();
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      checks++;
      if (ov !== 1'b0 || od !== '0) begin
        fails++;
        $display("FAIL R1 cyc=%0d got=%h exp=000", cyc, {ov, od});
      end
    end
  endtask

  task automatic t_zero();
    dsel = '0;
    for (int k = 0; k < 12; k++) begin
      step();
      check(0, "R2");
    end
  endtask

  task automatic t_powers();
    for (int b = 0; b < NS; b++) settle_and_check(1 << b, 4, "R4");
  endtask

  task automatic t_sums();
    settle_and_check(5, 6, "R5");
    settle_and_check(42, 6, "R5");
    settle_and_check(63, 6, "R5");
  endtask

  task automatic t_hold();
    settle_and_check(9, 30, "R3");
  endtask

  task automatic t_valid();
    settle_and_check(17, 20, "R7");
  endtask

  task automatic t_bypassed_shift();
    dsel = '0;
    for (int k = 0; k < 70; k++) step();
    dsel = NS'(32);
    for (int k = 0; k < 8; k++) begin
      step();
      check(32, "R6");
    end
    dsel = '0;
    for (int k = 0; k < 70; k++) step();
    dsel = NS'(1);
    for (int k = 0; k < 4; k++) begin
      step();
      check(1, "R6");
    end
  endtask

  task automatic t_change();
    settle_and_check(5, 3, "R8");
    dsel = NS'(12);
    for (int k = 0; k < 12; k++) step();
    for (int k = 0; k < 10; k++) begin
      step();
      check(12, "R8");
    end
  endtask

  initial begin
    for (int k = 0; k < HL; k++) hist[k] = '0;
    t_reset();
    t_zero();
    t_powers();
    t_sums();
    t_hold();
    t_valid();
    t_bypassed_shift();
    t_change();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired cyc=%0d got=running exp=finished", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end
endmodule